// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block drives the reset line of a microcontroller. It has two causes of reset. The first is a supply-good flag, which stands in for an external voltage comparator. The second is an active-low manual reset request, which comes from a pushbutton or from another block. While either cause is present, reset is asserted. When every cause has cleared, reset stays asserted for a further recovery period and then releases. The recovery period is a parameter counted in clock cycles. Any cause that comes back during the recovery period sends the block back to holding, and the count starts again from zero. As a result, every reset event lasts at least one full recovery period, however short its cause was.

The manual request has no debounce filter, so a pulse as short as one clock is still seen. It passes through a two-flop synchronizer before use. The supply-good flag is treated as already synchronous, because it comes from on-chip comparator logic. It is acted on at the next clock edge.

The block is a three-state machine. The states are:
- **ST_HOLD**: a cause is present.
- **ST_RECOVER**: the release timer is counting.
- **ST_RUN**: reset is released.

The transitions are:
- **cause_seen**: from ST_RUN or ST_RECOVER to ST_HOLD.
- **cause_gone**: from ST_HOLD to ST_RECOVER, with the timer at zero.
- **period_done**: from ST_RECOVER to ST_RUN.

The block's own asynchronous reset puts it in ST_RECOVER with the timer at zero. Three outputs are derived from the state: an active-low reset, its active-high complement, and a reset-active status.

Top module: `sup_rst_gen`

## Requirements
- R1: While `arst_n` is low, reset is asserted. After `arst_n` rises, reset stays asserted through REC_CYCLES clock edges and is released after the REC_CYCLES-th edge, provided no cause is present.
- R2: If `supply_ok` is sampled low at a clock edge, reset is asserted after that same edge.
- R3: If `mr_n` is sampled low at edge m, reset is asserted after edge m+2. Reset stays asserted while `mr_n` stays low.
- R4: A low pulse on `mr_n` that lasts a single clock is still recognised and gives a full-length reset.
- R5: Let e be the last edge at which a cause was present. For `supply_ok`, e is the last edge where it was sampled low. For `mr_n`, e is two edges after the last edge where it was sampled low. Reset is released after edge e+REC_CYCLES+1 and stays asserted until then.
- R6: A cause that returns while the release timer is counting restarts the full recovery period, measured from the point where that cause clears.
- R7: `rst_o` is always the logical inverse of `rst_n_o` (1 = reset asserted).
- R8: `rst_active_o` is 1 exactly when reset is asserted.
- R9: While no cause is present and the recovery period has ended, reset stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous power-on reset of the block, active low |
| supply_ok | input | 1 | 1 = supply above threshold; 0 = supply low, which is a reset cause |
| mr_n | input | 1 | Manual reset request, active low, asynchronous |
| rst_n_o | output | 1 | Reset to the microcontroller, active low |
| rst_o | output | 1 | Same reset, active high |
| rst_active_o | output | 1 | Status: reset currently asserted |

## Verification
The assertions assume three things about the inputs:
- `supply_ok` is already synchronous to `clk`.
- `mr_n` is stable for at least one clock whenever it is low.
- `arst_n` is released only between clock edges.

The stimulus follows these assumptions. It changes every input shortly after a rising edge, and it holds each level for whole clock periods. The shortest manual pulse it drives lasts exactly one clock. The supply-drop stimulus falls both while reset is released and while the release timer is running. This exercises both ways into the holding state.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_RECOVER = 2'd1,
        ST_RUN     = 2'd2
    } sup_state_t;

endpackage

// File: rtl/sup_rst_sync.sv
module sup_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/sup_rst_timer.sv
module sup_rst_timer #(
    parameter int REC_CYCLES = 20
) (
    input  logic clk,
    input  logic arst_n,
    input  logic run,
    output logic done
);

    localparam int CW = $clog2(REC_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(REC_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sup_rst_fsm.sv
module sup_rst_fsm
    import sup_rst_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic cause,
    input  logic tmr_done,
    output logic tmr_run,
    output logic rst_asserted
);

    sup_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HOLD:    if (!cause) state_nx = ST_RECOVER;
            ST_RECOVER: begin
                if (cause)         state_nx = ST_HOLD;
                else if (tmr_done) state_nx = ST_RUN;
            end
            ST_RUN:     if (cause) state_nx = ST_HOLD;
            default:    state_nx = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state <= ST_RECOVER;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        tmr_run      = (state == ST_RECOVER);
        rst_asserted = (state != ST_RUN);
    end

endmodule

// File: rtl/sup_rst_gen.sv
module sup_rst_gen #(
    parameter int REC_CYCLES  = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic supply_ok,
    input  logic mr_n,
    output logic rst_n_o,
    output logic rst_o,
    output logic rst_active_o
);

    logic mr_n_s;
    logic cause;
    logic tmr_run;
    logic tmr_done;
    logic asserted;

    sup_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .arst_n   (arst_n),
        .async_in (mr_n),
        .sync_out (mr_n_s)
    );

    assign cause = !supply_ok || !mr_n_s;

    sup_rst_timer #(.REC_CYCLES(REC_CYCLES)) u_timer (
        .clk    (clk),
        .arst_n (arst_n),
        .run    (tmr_run),
        .done   (tmr_done)
    );

    sup_rst_fsm u_fsm (
        .clk          (clk),
        .arst_n       (arst_n),
        .cause        (cause),
        .tmr_done     (tmr_done),
        .tmr_run      (tmr_run),
        .rst_asserted (asserted)
    );

    assign rst_n_o      = !asserted;
    assign rst_o        = asserted;
    assign rst_active_o = asserted;

endmodule

// File: rtl/sup_rst_gen_chk.sv
module sup_rst_gen_chk #(
    parameter int REC_CYCLES = 20
) (
    input logic clk,
    input logic arst_n,
    input logic supply_ok,
    input logic rst_n_o,
    input logic rst_o,
    input logic rst_active_o
);

    localparam int CW = $clog2(REC_CYCLES + 2);

    logic [CW-1:0] lo_cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            lo_cnt <= '0;
        end else if (rst_n_o) begin
            lo_cnt <= '0;
        end else if (lo_cnt != CW'(REC_CYCLES)) begin
            lo_cnt <= lo_cnt + 1'b1;
        end
    end

    // R2
    supply_drop_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !supply_ok |=> !rst_n_o);

    // R5
    min_width_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(rst_n_o) |-> (lo_cnt >= CW'(REC_CYCLES)));

    // R7
    polarity_chk: assert property (@(posedge clk) disable iff (!arst_n)
        rst_o != rst_n_o);

    // R8
    status_chk: assert property (@(posedge clk) disable iff (!arst_n)
        rst_active_o == !rst_n_o);

endmodule

bind sup_rst_gen sup_rst_gen_chk #(.REC_CYCLES(REC_CYCLES)) u_chk (
    .clk          (clk),
    .arst_n       (arst_n),
    .supply_ok    (supply_ok),
    .rst_n_o      (rst_n_o),
    .rst_o        (rst_o),
    .rst_active_o (rst_active_o)
);

// File: tb/tb_sup_rst_gen.sv
module tb_sup_rst_gen;

    localparam int CLK_PERIOD = 10;
    localparam int REC        = 20;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic mr_n = 1'b1;
    logic rst_n_o, rst_o, rst_active_o;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sup_rst_gen #(.REC_CYCLES(REC)) dut (
        .clk          (clk),
        .arst_n       (arst_n),
        .supply_ok    (supply_ok),
        .mr_n         (mr_n),
        .rst_n_o      (rst_n_o),
        .rst_o        (rst_o),
        .rst_active_o (rst_active_o)
    );

    // Reference model: a queue for the manual-reset delay, plus a count of
    // consecutive cause-free edges.
    bit mq[$];
    int quiet;
    bit exp_rst;

    initial begin
        mq = '{1'b1, 1'b1};
        quiet = 1;
    end

    always @(posedge clk) begin
        if (!arst_n) begin
            mq = '{1'b1, 1'b1};
            quiet = 1;
        end else begin
            bit cause;
            cause = !supply_ok || !mq[0];
            void'(mq.pop_front());
            mq.push_back(mr_n);
            if (cause) quiet = 0;
            else if (quiet < 100000) quiet = quiet + 1;
        end
    end

    assign exp_rst = (quiet <= REC);

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (arst_n && !done_flag) begin
            check(rst_n_o == !exp_rst, "R5", rst_n_o, !exp_rst);
            check(rst_o == exp_rst, "R7", rst_o, exp_rst);
            check(rst_active_o == exp_rst, "R8", rst_active_o, exp_rst);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_rst(input bit asserted, input string req);
        check(rst_n_o == !asserted, req, rst_n_o, !asserted);
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(3);
        // R1: asserted during block reset
        expect_rst(1, "R1");
        check(rst_o == 1, "R1", rst_o, 1);
        arst_n = 1'b1;
        tick(REC - 1);
        expect_rst(1, "R1");
        tick(1);
        expect_rst(0, "R1");
        tick(3);
        expect_rst(0, "R9");

        // R2 / R5: supply drop while released
        supply_ok = 1'b0;
        tick(1);
        expect_rst(1, "R2");
        tick(5);
        expect_rst(1, "R2");
        supply_ok = 1'b1;
        tick(REC);
        expect_rst(1, "R5");
        tick(1);
        expect_rst(0, "R5");

        // R3: manual reset latency and hold
        mr_n = 1'b0;
        tick(2);
        expect_rst(0, "R3");
        tick(1);
        expect_rst(1, "R3");
        tick(10);
        expect_rst(1, "R3");
        mr_n = 1'b1;
        tick(REC + 2);
        expect_rst(1, "R3");
        tick(1);
        expect_rst(0, "R3");

        // R4: single-clock manual pulse
        tick(2);
        mr_n = 1'b0;
        tick(1);
        mr_n = 1'b1;
        tick(2);
        expect_rst(1, "R4");
        tick(REC);
        expect_rst(1, "R4");
        tick(1);
        expect_rst(0, "R4");

        // R6: supply dip during recovery restarts the period
        supply_ok = 1'b0;
        tick(1);
        supply_ok = 1'b1;
        tick(10);
        expect_rst(1, "R6");
        supply_ok = 1'b0;
        tick(1);
        supply_ok = 1'b1;
        tick(REC);
        expect_rst(1, "R6");
        tick(1);
        expect_rst(0, "R6");

        // R9: stays released with no cause
        tick(30);
        expect_rst(0, "R9");
        check(rst_active_o == 0, "R8", rst_active_o, 0);

        tick(2);
        finish_run();
    end

endmodule